// File: doc/BRIEF.md
# IO Virtual Address Translator

This block turns 32-bit DMA virtual addresses issued by devices into physical addresses. The translations live in a linear table in memory, and the table sits at a base address set by configuration. The virtual window that the table covers always ends at the top of the 32-bit space, and its size is set by a 3-bit size code. A request is first looked up in a small, fully associative translation cache. On a miss, the block fetches one 64-bit table entry through a single-beat memory read port. It then checks the entry's valid and write-permission bits, fills the cache when the entry is usable, and returns either a physical address or a fault code.

A flush command carrying a virtual address drops any cached translation for that page. When the unit is disabled, addresses pass through unchanged. Only one table fetch is in flight at a time.

The control logic is a three-state machine:
- `ST_IDLE` accepts requests and answers cache hits, pass-through requests and window faults directly.
- A miss moves the machine to `ST_FETCH` (transition *miss*), where the memory read is offered until it is taken.
- The transition *issued* leads to `ST_WAIT`, where the machine waits for read data.
- The transition *returned* goes back to `ST_IDLE` and produces the response.

Top module: `iova_xlate`

## Requirements
- R1: With `cfg_enable` low, an accepted request answers in the next cycle with `rsp_paddr` equal to the zero-extended virtual address, `rsp_fault` = 0 (none) and `rsp_cacheable` = 0. No memory read is issued.
- R2: The window base is 2^32 − (8 MB << n), where n = `cfg_tbl_size`. With the unit enabled, an address below the base answers in the next cycle with `rsp_fault` = 1 (invalid) and issues no memory read.
- R3: On a cache miss inside the window, exactly one memory read is issued, at `cfg_tbl_base` + (((vaddr − base) >> 13) << 3).
- R4: For a fetched entry, bit 63 is valid, bit 1 is write permission, bit 4 is cacheable and bits 42:13 are the physical page. If bit 63 is clear, the response is fault 1. If the entry is usable, `rsp_paddr` = {entry[42:13], vaddr[12:0]} and `rsp_cacheable` = entry[4]. The response comes in the cycle after the memory data is accepted.
- R5: A write whose fetched entry has bit 1 clear gets fault 2 (protection). A read of the same entry succeeds.
- R6: Responses with a fault never fill the cache, so the next access to that page fetches again.
- R7: A cache hit issues no memory read and answers in the cycle after acceptance.
- R8: The cache holds 16 translations and replaces them in round-robin order, so the 17th distinct fill evicts the first.
- R9: A flush drops the cached translation of its page, so the next access to that page fetches again.
- R10: While `flush_valid` is high, `req_ready` is low and no request is taken.
- R11: `req_ready` stays low from a miss until its response. `mem_req_addr` is held stable while `mem_req_valid` waits for `mem_req_ready`.
- R12: A write that hits a cached translation lacking write permission gets fault 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_enable | input | 1 | Translation enable |
| cfg_tbl_size | input | 3 | Window/table size code n |
| cfg_tbl_base | input | 43 | Physical base of the table |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Request accepted when high |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Request is a write |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 43 | Physical address |
| rsp_fault | output | 2 | 0 none, 1 invalid, 2 protection |
| rsp_cacheable | output | 1 | Page cacheable attribute |
| flush_valid | input | 1 | Flush command |
| flush_vaddr | input | 32 | Address whose page is flushed |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Table read taken |
| mem_req_addr | output | 43 | Table entry address |
| mem_rsp_valid | input | 1 | Table read data valid |
| mem_rsp_data | input | 64 | Table entry |

## Verification
Pass-through answers, window faults and cache hits are due exactly one cycle after the request is accepted. A fetched answer is due one cycle after the cycle in which read data is presented. The bench counts falling edges from acceptance, and from the data beat, and compares the strobe's position against these figures. The bench's memory responder inserts random delays before taking the read and before returning data, so the fetch-path timing is checked against a moving stimulus.

// File: rtl/iova_pkg.sv
package iova_pkg;
    localparam int ENT_SHIFT   = 3;
    localparam int ENT_VALID   = 63;
    localparam int ENT_CACHE   = 4;
    localparam int ENT_WRITE   = 1;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_INVALID = 2'd1,
        FLT_PROTECT = 2'd2
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT
    } walk_state_e;
endpackage

// File: rtl/iova_window.sv
module iova_window
    import iova_pkg::*;
#(
    parameter int VA_W         = 32,
    parameter int PA_W         = 43,
    parameter int PG_SHIFT     = 13,
    parameter int SIZE_W       = 3,
    parameter int WIN_MIN_LOG2 = 23
) (
    input  logic [SIZE_W-1:0] size_code,
    input  logic [VA_W-1:0]   vaddr,
    input  logic [PA_W-1:0]   tbl_base,
    output logic              in_window,
    output logic [PA_W-1:0]   entry_addr
);
    logic [VA_W-1:0] span, base, offset;

    always_comb begin
        span       = {{(VA_W-1){1'b0}}, 1'b1} << (WIN_MIN_LOG2 + int'(size_code));
        base       = ~(span - {{(VA_W-1){1'b0}}, 1'b1});
        in_window  = vaddr >= base;
        offset     = vaddr - base;
        entry_addr = tbl_base + (PA_W'(offset >> PG_SHIFT) << ENT_SHIFT);
    end
endmodule

// File: rtl/iova_tcache.sv
module iova_tcache #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 19,
    parameter int PPN_W   = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    output logic             lk_cache,
    output logic             lk_write,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_cache,
    input  logic             fill_write,
    input  logic             flush_en,
    input  logic [VPN_W-1:0] flush_vpn
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] vld, hit_vec, cch, wrt;
    logic [VPN_W-1:0]   tag [ENTRIES];
    logic [PPN_W-1:0]   ppn [ENTRIES];
    logic [IDX_W-1:0]   ptr;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_way
        logic here;
        assign here       = fill_en && (ptr == IDX_W'(i));
        assign hit_vec[i] = vld[i] && (tag[i] == lk_vpn);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld[i] <= 1'b0;
            end else if (flush_en && (here ? (fill_vpn == flush_vpn)
                                           : (tag[i] == flush_vpn))) begin
                vld[i] <= 1'b0;
            end else if (here) begin
                vld[i] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (here) begin
                tag[i] <= fill_vpn;
                ppn[i] <= fill_ppn;
                cch[i] <= fill_cache;
                wrt[i] <= fill_write;
            end
        end
    end

    always_comb begin
        lk_hit   = |hit_vec;
        lk_ppn   = '0;
        lk_cache = 1'b0;
        lk_write = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) begin
                lk_ppn   = lk_ppn | ppn[i];
                lk_cache = lk_cache | cch[i];
                lk_write = lk_write | wrt[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              ptr <= '0;
        else if (fill_en)        ptr <= (ptr == IDX_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
    end

    // R8: fills only follow misses, so no page can occupy two ways
    assert_single_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: rtl/iova_xlate.sv
module iova_xlate
    import iova_pkg::*;
#(
    parameter int VA_W         = 32,
    parameter int PA_W         = 43,
    parameter int PG_SHIFT     = 13,
    parameter int SIZE_W       = 3,
    parameter int WIN_MIN_LOG2 = 23,
    parameter int TC_ENTRIES   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic [SIZE_W-1:0] cfg_tbl_size,
    input  logic [PA_W-1:0]   cfg_tbl_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_write,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [1:0]        rsp_fault,
    output logic              rsp_cacheable,
    input  logic              flush_valid,
    input  logic [VA_W-1:0]   flush_vaddr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [63:0]       mem_rsp_data
);
    localparam int VPN_W = VA_W - PG_SHIFT;
    localparam int PPN_W = PA_W - PG_SHIFT;

    walk_state_e      state, nstate;
    logic             in_win, req_fire, need_walk;
    logic [PA_W-1:0]  ent_addr, cur_addr;
    logic [VA_W-1:0]  cur_va;
    logic             cur_wr;
    logic             lk_hit, lk_cache, lk_write;
    logic [PPN_W-1:0] lk_ppn;
    logic             e_valid, e_write, e_cache, fill_en;
    logic [PPN_W-1:0] e_ppn;
    fault_e           walk_fault;
    logic             ent_unused;

    iova_window #(
        .VA_W(VA_W), .PA_W(PA_W), .PG_SHIFT(PG_SHIFT),
        .SIZE_W(SIZE_W), .WIN_MIN_LOG2(WIN_MIN_LOG2)
    ) u_window (
        .size_code  (cfg_tbl_size),
        .vaddr      (req_vaddr),
        .tbl_base   (cfg_tbl_base),
        .in_window  (in_win),
        .entry_addr (ent_addr)
    );

    iova_tcache #(.ENTRIES(TC_ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_tcache (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_vpn     (req_vaddr[VA_W-1:PG_SHIFT]),
        .lk_hit     (lk_hit),
        .lk_ppn     (lk_ppn),
        .lk_cache   (lk_cache),
        .lk_write   (lk_write),
        .fill_en    (fill_en),
        .fill_vpn   (cur_va[VA_W-1:PG_SHIFT]),
        .fill_ppn   (e_ppn),
        .fill_cache (e_cache),
        .fill_write (e_write),
        .flush_en   (flush_valid),
        .flush_vpn  (flush_vaddr[VA_W-1:PG_SHIFT])
    );

    // Entry decode and verdict for a fetched entry
    assign e_valid    = mem_rsp_data[ENT_VALID];
    assign e_write    = mem_rsp_data[ENT_WRITE];
    assign e_cache    = mem_rsp_data[ENT_CACHE];
    assign e_ppn      = mem_rsp_data[PA_W-1:PG_SHIFT];
    assign ent_unused = ^{mem_rsp_data[62:PA_W], mem_rsp_data[PG_SHIFT-1:5],
                          mem_rsp_data[3:2], mem_rsp_data[0]};
    assign walk_fault = !e_valid              ? FLT_INVALID :
                        (cur_wr && !e_write)  ? FLT_PROTECT : FLT_NONE;
    assign fill_en    = (state == ST_WAIT) && mem_rsp_valid && (walk_fault == FLT_NONE);

    assign req_ready     = (state == ST_IDLE) && !flush_valid;
    assign req_fire      = req_valid && req_ready;
    assign need_walk     = req_fire && cfg_enable && in_win && !lk_hit;
    assign mem_req_valid = (state == ST_FETCH);
    assign mem_req_addr  = cur_addr;

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:  if (need_walk)     nstate = ST_FETCH;
            ST_FETCH: if (mem_req_ready) nstate = ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid) nstate = ST_IDLE;
            default:                     nstate = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    always_ff @(posedge clk) begin
        if (req_fire) begin
            cur_va   <= req_vaddr;
            cur_wr   <= req_write;
            cur_addr <= ent_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_paddr     <= '0;
            rsp_fault     <= FLT_NONE;
            rsp_cacheable <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state)
                ST_IDLE: if (req_fire && !need_walk) begin
                    rsp_valid <= 1'b1;
                    if (!cfg_enable) begin
                        rsp_paddr     <= PA_W'(req_vaddr);
                        rsp_fault     <= FLT_NONE;
                        rsp_cacheable <= 1'b0;
                    end else if (!in_win) begin
                        rsp_paddr     <= '0;
                        rsp_fault     <= FLT_INVALID;
                        rsp_cacheable <= 1'b0;
                    end else begin
                        rsp_paddr     <= {lk_ppn, req_vaddr[PG_SHIFT-1:0]};
                        rsp_fault     <= (req_write && !lk_write) ? FLT_PROTECT : FLT_NONE;
                        rsp_cacheable <= lk_cache;
                    end
                end
                ST_FETCH: ;
                ST_WAIT: if (mem_rsp_valid) begin
                    rsp_valid     <= 1'b1;
                    rsp_paddr     <= {e_ppn, cur_va[PG_SHIFT-1:0]};
                    rsp_fault     <= walk_fault;
                    rsp_cacheable <= e_cache;
                end
                default: ;
            endcase
        end
    end

    assert_pass_through_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_fire && !cfg_enable) |=>
            (rsp_valid && rsp_fault == FLT_NONE && rsp_paddr == PA_W'($past(req_vaddr))));

    assert_below_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_fire && cfg_enable && !in_win) |=> (rsp_valid && rsp_fault == FLT_INVALID && !mem_req_valid));

    assert_accept_progress_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_fire |=> (rsp_valid || mem_req_valid));

    assert_walk_answer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && mem_rsp_valid) |=> rsp_valid);

    assert_fetch_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
endmodule

// File: tb/iova_xlate_test.sv
`timescale 1ns/1ps
module iova_xlate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b0;
    logic [2:0]  cfg_tbl_size = 3'd0;
    logic [42:0] cfg_tbl_base = '0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_ready, rsp_valid, rsp_cacheable, mem_req_valid;
    logic [42:0] rsp_paddr, mem_req_addr;
    logic [1:0]  rsp_fault;
    logic        flush_valid = 1'b0;
    logic [31:0] flush_vaddr = '0;
    logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;

    int compared = 0, mismatched = 0;

    // reference cache model
    logic [18:0] mtag [16];
    logic [29:0] mppn [16];
    bit          mv [16], mc [16], mw [16];
    int          mptr = 0;

    always #2 clk = ~clk;

    iova_xlate uut (.*);

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    function automatic logic [63:0] ent(input logic [42:0] a);
        logic [63:0] e = '0;
        e[63]    = (a[5:3] != 3'd7);
        e[42:13] = a[32:3] ^ 30'h2A5C3;
        e[4]     = a[6];
        e[1]     = (a[4:3] != 2'd1);
        e[60]    = 1'b1;
        return e;
    endfunction

    function automatic logic [31:0] wbase(input logic [2:0] n);
        return 32'd0 - (32'd1 << (23 + n));
    endfunction

    task automatic xlate(input logic [31:0] va, input bit wr, input string rq);
        logic [31:0] base = wbase(cfg_tbl_size);
        logic [42:0] exp_addr = '0, waddr = '0;
        logic [42:0] exp_pa = '0;
        logic [63:0] e;
        bit exp_walk = 0, exp_c = 0, walked = 0, got = 0, busy_bad = 0;
        logic [1:0] exp_f = 2'd0;
        int hit = -1, lat = 0, rsp_lat = 1, phase = 0, dly;
        for (int i = 0; i < 16; i++) if (mv[i] && mtag[i] == va[31:13]) hit = i;
        if (!cfg_enable) begin
            exp_pa = {11'd0, va};
        end else if (va < base) begin
            exp_f = 2'd1;
        end else if (hit >= 0) begin
            exp_f  = (wr && !mw[hit]) ? 2'd2 : 2'd0;
            exp_pa = {mppn[hit], va[12:0]};
            exp_c  = mc[hit];
        end else begin
            exp_walk = 1;
            exp_addr = cfg_tbl_base + (43'((va - base) >> 13) << 3);
            e = ent(exp_addr);
            exp_f  = !e[63] ? 2'd1 : (wr && !e[1]) ? 2'd2 : 2'd0;
            exp_pa = {e[42:13], va[12:0]};
            exp_c  = e[4];
            if (exp_f == 2'd0) begin
                mtag[mptr] = va[31:13]; mppn[mptr] = e[42:13];
                mc[mptr] = e[4]; mw[mptr] = e[1]; mv[mptr] = 1;
                mptr = (mptr + 1) % 16;
            end
        end
        @(negedge clk);
        req_valid = 1; req_vaddr = va; req_write = wr;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 0; lat = 1; dly = $urandom % 3;
        for (int it = 0; it < 60; it++) begin
            mem_req_ready = 0; mem_rsp_valid = 0;
            if (rsp_valid) begin got = 1; break; end
            if (req_ready) busy_bad = 1;
            if (phase == 0 && mem_req_valid) begin
                if (dly == 0) begin
                    walked = 1; waddr = mem_req_addr; mem_req_ready = 1;
                    phase = 1; dly = $urandom % 3;
                end else dly--;
            end else if (phase == 1) begin
                if (dly == 0) begin
                    mem_rsp_valid = 1; mem_rsp_data = ent(waddr);
                    phase = 2; rsp_lat = lat + 1;
                end else dly--;
            end
            @(negedge clk); lat++;
        end
        check(got, rq, "response arrived", 64'(got), 64'd1);
        if (!got) return;
        check(rsp_fault == exp_f, rq, "fault", 64'(rsp_fault), 64'(exp_f));
        if (exp_f == 2'd0) begin
            check(rsp_paddr == exp_pa, rq, "paddr", 64'(rsp_paddr), 64'(exp_pa));
            check(rsp_cacheable == exp_c, rq, "cacheable", 64'(rsp_cacheable), 64'(exp_c));
        end
        check(walked == exp_walk, rq, "table read issued", 64'(walked), 64'(exp_walk));
        if (exp_walk && walked) begin
            check(waddr == exp_addr, {rq, "/R3"}, "entry addr", 64'(waddr), 64'(exp_addr));
            check(!busy_bad, {rq, "/R11"}, "ready low during walk", 64'(busy_bad), 64'd0);
        end
        check(lat == (walked ? rsp_lat : 1), {rq, "/R7"}, "latency",
              64'(lat), 64'(walked ? rsp_lat : 1));
    endtask

    task automatic flush(input logic [31:0] va);
        @(negedge clk);
        flush_valid = 1; flush_vaddr = va;
        req_valid = 1; req_vaddr = va ^ 32'h0000_4000; req_write = 0;
        #1;
        check(req_ready == 1'b0, "R10", "ready during flush", 64'(req_ready), 64'd0);
        @(negedge clk);
        flush_valid = 0; req_valid = 0;
        check(rsp_valid == 1'b0, "R10", "no answer to blocked request", 64'(rsp_valid), 64'd0);
        for (int i = 0; i < 16; i++) if (mv[i] && mtag[i] == va[31:13]) mv[i] = 0;
    endtask

    initial begin
        #(4 * 180000);
        mismatched++; compared++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) mv[i] = 0;
        repeat (3) @(negedge clk);
        check(rsp_valid == 0 && mem_req_valid == 0, "R11", "reset outputs",
              64'({rsp_valid, mem_req_valid}), 64'd0);
        rst_n = 1;
        @(negedge clk);
        check(req_ready == 1, "R11", "ready after reset", 64'(req_ready), 64'd1);

        // R1 pass-through
        xlate(32'h1234_5678, 1, "R1");
        xlate(32'hFFFF_FFFF, 0, "R1");

        cfg_enable = 1; cfg_tbl_size = 3'd0; cfg_tbl_base = 43'h100_0000_0000 >> 4;
        xlate(32'hFF7F_FFFF, 0, "R2");
        xlate(32'hFF80_0123, 0, "R3");
        xlate(32'hFF80_0055, 1, "R7");
        xlate(32'hFFFF_FFFF, 0, "R4");
        xlate(32'hFFFF_FFFF, 0, "R6");
        xlate(32'hFF80_2010, 1, "R5");
        xlate(32'hFF80_2010, 1, "R6");
        xlate(32'hFF80_2020, 0, "R5");
        xlate(32'hFF80_2030, 1, "R12");
        flush(32'hFF80_0000);
        xlate(32'hFF80_0777, 0, "R9");

        cfg_tbl_size = 3'd2;
        for (int k = 0; k < 17; k++) xlate(wbase(3'd2) + 32'(k * 8) * 32'h2000, 0, "R8");
        xlate(wbase(3'd2) + 32'h10, 0, "R8");

        for (int n = 0; n < 400; n++) begin
            logic [31:0] b;
            if (n % 50 == 0) cfg_tbl_size = 3'($urandom % 8);
            cfg_enable = ($urandom % 16) != 0;
            b = wbase(cfg_tbl_size);
            if ($urandom % 10 == 0)
                flush(b + 32'($urandom % 24) * 32'h2000);
            else if ($urandom % 10 == 0)
                xlate(b - 32'd1 - ($urandom % 4096), $urandom % 2, "R2");
            else
                xlate(b + 32'($urandom % 24) * 32'h2000 + ($urandom % 8192), $urandom % 2, "R4");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule